// File: doc/BRIEF.md
# Toggle-on-Match Pulse Generator

This block makes a pulse waveform from a 16-bit up-counter and two compare registers, a period register and a duty register. While enabled, the counter starts at zero and increments every clock. When the count equals the period value, the counter wraps to zero. The single output inverts on every match with either register, so the duty match marks the edge in the middle of the cycle and the period match marks the edge at the end of the cycle. Each match also raises a one-clock interrupt pulse of its own.

No shadow copy holds the duty register. A write lands on the next clock edge and is compared from then on. A mistimed rewrite therefore produces the same waveform errors that a real unbuffered timer shows. A larger value written after the duty match causes a second inversion in the same cycle. A value written below the current count before the match causes the cycle to skip its duty inversion, and the high and low phases swap. Equal duty and period values are an illegal setting. In that case the output inverts only once and an error pulse is raised. When enable is low, the counter is held at zero and the output is driven to a programmable idle level.

Top module: `toggle_match_pwm`

## Requirements
- R1: While `enable` is high, the count starts at 0 after enable rises and increments by one per clock. It returns to 0 on the clock after the count equals the period value, so `periodIrq` pulses once every period+1 clocks.
- R2: On the clock edge at which the count equals the period value, `pwmOut` inverts and `periodIrq` is high for the following clock cycle.
- R3: On the clock edge at which the count equals the duty value, `pwmOut` inverts and `dutyIrq` is high for the following clock cycle. `pwmOut` inverts at no other edge while enabled.
- R4: A write drives `wrEn`=1 with `wrSel`=0 to select the period register or `wrSel`=1 to select the duty register. The register takes `wrData` at that clock edge, and the comparison made at that same edge still uses the old register value.
- R5: A duty rewrite to a larger value after the duty match in the current cycle causes a second duty match in that cycle. The output then returns to the level it had before the first duty match.
- R6: A duty rewrite to a value below the current count, made before the duty match, suppresses the duty match for the rest of that cycle. No `dutyIrq` occurs until the period match.
- R7: When the count equals both registers at once, `pwmOut` inverts only once, both interrupts pulse, and `cfgErr` is high for the following clock cycle. `cfgErr` is never high otherwise.
- R8: While `enable` is low, the count is held at 0, `pwmOut` follows `idleLevel` one clock later, and neither interrupt nor `cfgErr` pulses. Register writes are still accepted.
- R9: After reset, the period register is 0xFFFF, the duty register is 0, and `pwmOut`, `periodIrq`, `dutyIrq` and `cfgErr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run the counter; low holds it at zero and idles the output |
| idleLevel | input | 1 | Output level while disabled |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 1 | Write target: 0 period, 1 duty |
| wrData | input | 16 | Write value |
| pwmOut | output | 1 | Toggle output |
| periodIrq | output | 1 | One-clock pulse after a period match |
| dutyIrq | output | 1 | One-clock pulse after a duty match |
| cfgErr | output | 1 | One-clock pulse when both matches coincide |

## Verification
The delicate collision is a duty-register write landing on the very edge at which the count meets that register. The bench provokes it by counting clocks from an observed period pulse and issuing the write so that it lands exactly on the matching count. It then judges that the old value decided that edge and that the new value governs the later edges. The second collision is a period match and a duty match on one count. This is forced with equal register values and judged by a single inversion together with the error pulse. A behavioural model compares all outputs on every clock, so both cases are also judged continuously.

// File: rtl/tmp_pkg.sv
package tmp_pkg;
  // strobes passed from compare control to the datapath
  typedef struct packed {
    logic run;        // counter enabled this clock
    logic clear;      // counter returns to zero
    logic toggle;     // output inverts
    logic periodHit;  // count equals period register
    logic dutyHit;    // count equals duty register
    logic bothHit;    // both matches in one clock
  } ctlStrobe_t;
endpackage

// File: rtl/tmp_ctrl.sv
module tmp_ctrl
  import tmp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             enable,
  input  logic [CNT_W-1:0] cntQ,
  input  logic [CNT_W-1:0] periodQ,
  input  logic [CNT_W-1:0] dutyQ,
  output ctlStrobe_t       strobe
);
  logic periodEq;
  logic dutyEq;

  // compares use the register contents before any write on this edge
  assign periodEq = (cntQ == periodQ);
  assign dutyEq   = (cntQ == dutyQ);

  always_comb begin
    strobe.run       = enable;
    strobe.periodHit = enable && periodEq;
    strobe.dutyHit   = enable && dutyEq;
    strobe.bothHit   = enable && periodEq && dutyEq;
    strobe.clear     = !enable || periodEq;
    // a coincident pair inverts only once
    strobe.toggle    = enable && (periodEq || dutyEq);
  end
endmodule

// File: rtl/tmp_datapath.sv
module tmp_datapath
  import tmp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             idleLevel,
  input  logic             wrEn,
  input  logic             wrSel,
  input  logic [CNT_W-1:0] wrData,
  input  ctlStrobe_t       strobe,
  output logic [CNT_W-1:0] cntQ,
  output logic [CNT_W-1:0] periodQ,
  output logic [CNT_W-1:0] dutyQ,
  output logic             pwmOut,
  output logic             periodIrq,
  output logic             dutyIrq,
  output logic             cfgErr
);
  localparam logic [CNT_W-1:0] PERIOD_RST = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] DUTY_RST   = '0;
  localparam logic [CNT_W-1:0] CNT_ONE    = {{(CNT_W-1){1'b0}}, 1'b1};

  // compare registers, written directly with no shadow stage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      periodQ <= PERIOD_RST;
      dutyQ   <= DUTY_RST;
    end else if (wrEn) begin
      if (wrSel) dutyQ   <= wrData;
      else       periodQ <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             cntQ <= '0;
    else if (strobe.clear) cntQ <= '0;
    else                   cntQ <= cntQ + CNT_ONE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              pwmOut <= 1'b0;
    else if (!strobe.run)   pwmOut <= idleLevel;
    else if (strobe.toggle) pwmOut <= ~pwmOut;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      periodIrq <= 1'b0;
      dutyIrq   <= 1'b0;
      cfgErr    <= 1'b0;
    end else begin
      periodIrq <= strobe.periodHit;
      dutyIrq   <= strobe.dutyHit;
      cfgErr    <= strobe.bothHit;
    end
  end
endmodule

// File: rtl/toggle_match_pwm.sv
module toggle_match_pwm
  import tmp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             idleLevel,
  input  logic             wrEn,
  input  logic             wrSel,
  input  logic [CNT_W-1:0] wrData,
  output logic             pwmOut,
  output logic             periodIrq,
  output logic             dutyIrq,
  output logic             cfgErr
);
  ctlStrobe_t       strobe;
  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] periodQ;
  logic [CNT_W-1:0] dutyQ;

  tmp_ctrl #(.CNT_W(CNT_W)) ctrl_i (
    .enable (enable),
    .cntQ   (cntQ),
    .periodQ(periodQ),
    .dutyQ  (dutyQ),
    .strobe (strobe)
  );

  tmp_datapath #(.CNT_W(CNT_W)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .idleLevel(idleLevel),
    .wrEn     (wrEn),
    .wrSel    (wrSel),
    .wrData   (wrData),
    .strobe   (strobe),
    .cntQ     (cntQ),
    .periodQ  (periodQ),
    .dutyQ    (dutyQ),
    .pwmOut   (pwmOut),
    .periodIrq(periodIrq),
    .dutyIrq  (dutyIrq),
    .cfgErr   (cfgErr)
  );
endmodule

// File: rtl/tmp_chk.sv
module tmp_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             enable,
  input logic             idleLevel,
  input logic [CNT_W-1:0] cntQ,
  input logic             pwmOut,
  input logic             periodIrq,
  input logic             dutyIrq,
  input logic             cfgErr
);
  logic armed;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  // R1
  period_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    periodIrq |-> (cntQ == '0));

  // R3
  toggle_only_on_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(enable)) |-> ((pwmOut != $past(pwmOut)) == (periodIrq || dutyIrq)));

  // R7
  err_needs_both_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgErr |-> (periodIrq && dutyIrq));

  // R8
  idle_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (pwmOut == $past(idleLevel)) && !periodIrq && !dutyIrq && !cfgErr && (cntQ == '0));

  // R2
  irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (armed && (periodIrq || dutyIrq)) |-> $past(enable));
endmodule

bind toggle_match_pwm tmp_chk #(.CNT_W(CNT_W)) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .enable   (enable),
  .idleLevel(idleLevel),
  .cntQ     (cntQ),
  .pwmOut   (pwmOut),
  .periodIrq(periodIrq),
  .dutyIrq  (dutyIrq),
  .cfgErr   (cfgErr)
);

// File: tb/toggle_match_pwm_tb_top.sv
module toggle_match_pwm_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG = 100000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0;
  logic idleLevel = 1'b0;
  logic wrEn = 1'b0;
  logic wrSel = 1'b0;
  logic [15:0] wrData = '0;
  logic pwmOut, periodIrq, dutyIrq, cfgErr;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  // behavioural reference state
  int mCnt, mPer, mDuty;
  bit mOut, mP, mD, mE;

  always #(CLK_PERIOD/2) clk = ~clk;

  toggle_match_pwm dut_i (
    .clk(clk), .rstN(rstN), .enable(enable), .idleLevel(idleLevel),
    .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .pwmOut(pwmOut), .periodIrq(periodIrq), .dutyIrq(dutyIrq), .cfgErr(cfgErr)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    bit ph, dh;
    if (!rstN) begin
      mCnt = 0; mPer = 16'hFFFF; mDuty = 0; mOut = 0; mP = 0; mD = 0; mE = 0;
    end else begin
      ph = enable && (mCnt == mPer);
      dh = enable && (mCnt == mDuty);
      if (enable) begin
        if (ph || dh) mOut = !mOut;
        mCnt = ph ? 0 : ((mCnt + 1) & 16'hFFFF);
      end else begin
        mCnt = 0;
        mOut = idleLevel;
      end
      mP = ph; mD = dh; mE = ph && dh;
      if (wrEn) begin
        if (wrSel) mDuty = int'(wrData);
        else       mPer  = int'(wrData);
      end
    end
  end

  // compare against the model on every clock, away from the edge
  always @(negedge clk) begin
    cycles++;
    if (rstN) begin
      chk(pwmOut == mOut, "R3 pwmOut", pwmOut, mOut);
      chk(periodIrq == mP, "R2 periodIrq", periodIrq, mP);
      chk(dutyIrq == mD, "R3 dutyIrq", dutyIrq, mD);
      chk(cfgErr == mE, "R7 cfgErr", cfgErr, mE);
    end
    if (cycles > WATCHDOG) begin
      chk(1'b0, "watchdog", cycles, WATCHDOG);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wrReg(input bit sel, input int val);
    wrEn = 1'b1; wrSel = sel; wrData = val[15:0];
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic waitPeriod();
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (periodIrq) return;
    end
    chk(1'b0, "R2 period pulse missing", 0, 1);
  endtask

  initial begin
    int gap, dCount;
    bit lvl;
    step(3);
    // R9 reset state
    chk(pwmOut == 1'b0 && periodIrq == 1'b0 && dutyIrq == 1'b0 && cfgErr == 1'b0,
        "R9 reset outputs", {pwmOut, periodIrq, dutyIrq, cfgErr}, 0);
    rstN = 1'b1;
    step(2);
    chk(pwmOut == 1'b0, "R9 idle after reset", pwmOut, 0);

    // R4 writes while disabled, then normal run
    wrReg(1'b0, 9);
    wrReg(1'b1, 3);
    enable = 1'b1;
    waitPeriod();
    gap = 0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk); gap++;
      if (periodIrq) break;
    end
    chk(gap == 10, "R1 period spacing", gap, 10);

    // R5 larger duty written after the duty match
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (dutyIrq) break;
    end
    lvl = pwmOut;
    wrReg(1'b1, 7);
    dCount = 0;
    for (int i = 0; i < 20; i++) begin
      if (dutyIrq) dCount++;
      if (periodIrq || dCount > 0) break;
      @(negedge clk);
    end
    chk(dCount == 1 && periodIrq == 1'b0, "R5 second duty match", dCount, 1);
    chk(pwmOut == !lvl, "R5 level restored", pwmOut, !lvl);

    // R6 duty moved below the count before its match
    waitPeriod();
    step(2);
    wrReg(1'b1, 1);
    dCount = 0;
    for (int i = 0; i < 30; i++) begin
      if (periodIrq) break;
      if (dutyIrq) dCount++;
      @(negedge clk);
    end
    chk(dCount == 0, "R6 duty match skipped", dCount, 0);
    dCount = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (dutyIrq) dCount++;
      if (periodIrq) break;
    end
    chk(dCount == 1, "R6 duty back next cycle", dCount, 1);

    // R4 write lands on the matching edge: old value decides
    wrReg(1'b1, 3);
    waitPeriod();
    step(3);
    wrReg(1'b1, 8);
    chk(dutyIrq == 1'b1, "R4 old duty used on write edge", dutyIrq, 1);
    step(6);

    // R7 equal registers
    wrReg(1'b0, 5);
    wrReg(1'b1, 5);
    for (int i = 0; i < 40; i++) begin
      lvl = pwmOut;
      @(negedge clk);
      if (cfgErr) break;
    end
    chk(cfgErr && periodIrq && dutyIrq, "R7 both pulses", {cfgErr, periodIrq, dutyIrq}, 7);
    chk(pwmOut == !lvl, "R7 single toggle", pwmOut, !lvl);
    step(14);

    // R8 disable with both idle levels
    idleLevel = 1'b1;
    enable = 1'b0;
    step(3);
    chk(pwmOut == 1'b1 && !periodIrq && !dutyIrq, "R8 idle high", pwmOut, 1);
    idleLevel = 1'b0;
    step(2);
    chk(pwmOut == 1'b0, "R8 idle low", pwmOut, 0);
    wrReg(1'b0, 4);
    wrReg(1'b1, 2);
    enable = 1'b1;
    gap = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk); gap++;
      if (periodIrq) break;
    end
    chk(gap == 5, "R8 restart from zero", gap, 5);
    step(20);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule